// File: doc/BRIEF.md
# Slave Configuration Table Decoder

This block sits behind a simple synchronous request/response port and covers a 2 MiB register window. It splits that window into four parts. At the bottom is a read-only table that describes the slave: a fixed chip identifier word, followed by one descriptor word for each engine on the attached local bus. Above that is an unmapped hole. Next comes a range forwarded to a slave-register port. The rest of the window, up to its end, is forwarded to a local-bus engine port.

Each descriptor word has a fixed layout. Bit 31 is set to say that another entry follows. Bits 23:16 hold a slot count of one. There is a 16-bit version value, a 4-bit type code in bits 7:4 and a constant 4-bit check nibble in bits 3:0. Software walks the table until it reads a zero word. A special magic value written to either of the two lowest table words resets the downstream local bus: the block raises a one-cycle cold-reset pulse toward it. No other write into the table has any effect.

Every request completes exactly one cycle later with `rspReady`. Read data is registered. A forwarded access drives its port select only during the request cycle, and the downstream read data is captured at the end of that cycle. Words travel with bit 31 as the first byte on the bus, and the block never swaps lanes.

Top module: `slave_cfg_decoder`

## Requirements
- R1: Each cycle with `reqValid` high is followed in the next cycle by `rspReady` high. A cycle without a request is followed by `rspReady` low. After reset, `rspReady`, `rspRdata`, `lbusColdReset` and both port selects are 0.
- R2: A full-word read at window offset 0x000 returns 0xC0022D15.
- R3: Full-word reads at 0x004, 0x008 and 0x00C return descriptor words. Each word is bit 31 set, plus 0x00010000, plus the version, plus the type shifted left by 4, plus the check nibble. The (type, version, check) triples are (2, 0x1000, 0xC), (3, 0x5000, 0xA) and (6, 0x1000, 0x7). This gives 0x8001102C, 0x8001503A and 0x80011067.
- R4: Full-word reads at table offsets 0x010 through 0x3FC return 0.
- R5: A full-word write of 0xC0DE0000 to offset 0x000 or 0x004 raises `lbusColdReset` for exactly one cycle, in the cycle where `rspReady` answers that write.
- R6: A write of any other value to 0x000 or 0x004, and any write to other table offsets, gives no pulse and leaves the table contents unchanged.
- R7: A table access whose byte enables are not 4'b1111, or whose address is not word aligned, completes normally. It reads 0 and causes no pulse.
- R8: Offsets 0x800–0xBFF raise `slvSel` during the request cycle only. `slvAddr` is the offset minus 0x800. `slvRdata` sampled in that cycle is returned on `rspRdata` with `rspReady`.
- R9: Offsets 0xC00–0x1FFFFF raise `engSel` during the request cycle only. `engAddr` is the offset minus 0xC00, and `engWrite`/`engWdata` carry the request. Read data returns as in R8, and a write returns 0.
- R10: Offsets 0x400–0x7FF raise no select, read 0 and discard writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 21 | Byte offset within the window |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data |
| reqByteEn | input | 4 | Byte lane enables |
| rspReady | output | 1 | Completion, one cycle after the request |
| rspRdata | output | 32 | Read data, valid with rspReady |
| slvSel | output | 1 | Slave-register port select |
| slvAddr | output | 10 | Offset inside the slave-register range |
| slvWrite | output | 1 | Slave-register port write |
| slvWdata | output | 32 | Slave-register port write data |
| slvRdata | input | 32 | Slave-register port read data |
| engSel | output | 1 | Engine port select |
| engAddr | output | 21 | Offset inside the engine range |
| engWrite | output | 1 | Engine port write |
| engWdata | output | 32 | Engine port write data |
| engRdata | input | 32 | Engine port read data |
| lbusColdReset | output | 1 | One-cycle cold reset toward the local bus |

## Verification
The bench builds the block with its default parameters: a 21-bit window address, a 1 KiB table, a 1 KiB slave-register range at 0x800 and the engine range from 0xC00. With these values the last word of the 2 MiB window (0x1FFFFC) and both edges of the slave range can be reached, so the subtraction that forms the forwarded address is tested at its extremes. The 4-word table size puts the first zero word at 0x010, so the chained descriptors end where software expects. The check covers the step from the last descriptor to that zero word.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  localparam logic [WORD_W-1:0] CHIP_ID_WORD = 32'hC0022D15;
  localparam logic [WORD_W-1:0] BREAK_WORD   = 32'hC0DE0000;
  localparam logic [WORD_W-1:0] MORE_FLAG    = 32'h8000_0000;
  localparam logic [WORD_W-1:0] ONE_SLOT     = 32'h0001_0000;

  // Control-to-datapath strobes for one request cycle
  typedef struct packed {
    logic respond;
    logic cfgRead;
    logic slvRead;
    logic engRead;
    logic breakHit;
  } strobe_t;

  function automatic logic [WORD_W-1:0] descWord(input logic [15:0] ver,
                                                 input logic [3:0]  kind,
                                                 input logic [3:0]  chk);
    return MORE_FLAG | ONE_SLOT | {16'h0, ver} | {24'h0, kind, 4'h0} | {28'h0, chk};
  endfunction

  // Word idx of the configuration table; zero past the last engine
  function automatic logic [WORD_W-1:0] tableWord(input int idx);
    case (idx)
      0:       return CHIP_ID_WORD;
      1:       return descWord(16'h1000, 4'h2, 4'hC);
      2:       return descWord(16'h5000, 4'h3, 4'hA);
      3:       return descWord(16'h1000, 4'h6, 4'h7);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/sctd_ctrl.sv
module sctd_ctrl
  import cfgwin_pkg::*;
#(
  parameter int WIN_AW   = 21,
  parameter int CFG_SPAN = 1024,
  parameter int SLV_BASE = 2048,
  parameter int SLV_SPAN = 1024,
  parameter int ENG_BASE = 3072,
  parameter int BREAK_WORDS = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [WIN_AW-1:0]            reqAddr,
  input  logic                         reqWrite,
  input  logic [WORD_W-1:0]            reqWdata,
  input  logic [LANES-1:0]             reqByteEn,
  output strobe_t                      strb,
  output logic [$clog2(CFG_SPAN)-3:0]  cfgWordIdx,
  output logic                         slvSel,
  output logic [$clog2(SLV_SPAN)-1:0]  slvAddr,
  output logic                         slvWrite,
  output logic [WORD_W-1:0]            slvWdata,
  output logic                         engSel,
  output logic [WIN_AW-1:0]            engAddr,
  output logic                         engWrite,
  output logic [WORD_W-1:0]            engWdata
);

  localparam int CFG_IDX_W = $clog2(CFG_SPAN) - 2;
  localparam int SLV_AW    = $clog2(SLV_SPAN);
  localparam logic [WIN_AW-1:0] cfgTopA  = WIN_AW'(CFG_SPAN);
  localparam logic [WIN_AW-1:0] slvBaseA = WIN_AW'(SLV_BASE);
  localparam logic [WIN_AW-1:0] slvTopA  = WIN_AW'(SLV_BASE + SLV_SPAN);
  localparam logic [WIN_AW-1:0] engBaseA = WIN_AW'(ENG_BASE);

  logic inCfg, inSlv, inEng, cfgFull;
  logic [WIN_AW-1:0] slvOffset;

  always_comb begin
    inCfg = reqAddr < cfgTopA;
    inSlv = (reqAddr >= slvBaseA) && (reqAddr < slvTopA);
    inEng = reqAddr >= engBaseA;
    cfgFull = (reqByteEn == {LANES{1'b1}}) && (reqAddr[1:0] == 2'b00);
  end

  assign cfgWordIdx = reqAddr[CFG_IDX_W+1:2];
  assign slvOffset  = reqAddr - slvBaseA;

  // Forwarded ports: select lives only in the request cycle
  assign slvSel   = reqValid && inSlv;
  assign slvAddr  = slvOffset[SLV_AW-1:0];
  assign slvWrite = reqWrite;
  assign slvWdata = reqWdata;
  assign engSel   = reqValid && inEng;
  assign engAddr  = reqAddr - engBaseA;
  assign engWrite = reqWrite;
  assign engWdata = reqWdata;

  always_comb begin
    strb          = '0;
    strb.respond  = reqValid;
    strb.cfgRead  = reqValid && inCfg && !reqWrite && cfgFull;
    strb.slvRead  = slvSel && !reqWrite;
    strb.engRead  = engSel && !reqWrite;
    strb.breakHit = reqValid && inCfg && reqWrite && cfgFull &&
                    (reqWdata == BREAK_WORD) &&
                    (cfgWordIdx < CFG_IDX_W'(BREAK_WORDS));
  end

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({slvSel, engSel}));  // R8
  AST_SEL_IN_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (slvSel || engSel) |-> reqValid);  // R9
  AST_HOLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= cfgTopA && reqAddr < slvBaseA) |-> !(slvSel || engSel));  // R10
  AST_BREAK_FULL_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strb.breakHit |-> (reqByteEn == {LANES{1'b1}}));  // R7

endmodule

// File: rtl/sctd_datapath.sv
module sctd_datapath
  import cfgwin_pkg::*;
#(
  parameter int CFG_IDX_W = 8,
  parameter int CFG_WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [CFG_IDX_W-1:0] cfgWordIdx,
  input  logic [WORD_W-1:0]    slvRdata,
  input  logic [WORD_W-1:0]    engRdata,
  output logic                 rspReady,
  output logic [WORD_W-1:0]    rspRdata,
  output logic                 lbusColdReset
);

  logic [WORD_W-1:0] romWord [CFG_WORDS];
  logic [WORD_W-1:0] romData;
  logic [WORD_W-1:0] rdNext;

  for (genvar g = 0; g < CFG_WORDS; g++) begin : gRom
    assign romWord[g] = tableWord(g);
  end

  // Word beyond the populated entries reads zero
  always_comb begin
    romData = '0;
    for (int i = 0; i < CFG_WORDS; i++)
      if (cfgWordIdx == CFG_IDX_W'(i)) romData = romWord[i];
  end

  always_comb begin
    rdNext = '0;
    if (strb.cfgRead)      rdNext = romData;
    else if (strb.slvRead) rdNext = slvRdata;
    else if (strb.engRead) rdNext = engRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspReady      <= 1'b0;
      rspRdata      <= '0;
      lbusColdReset <= 1'b0;
    end else begin
      rspReady      <= strb.respond;
      rspRdata      <= strb.respond ? rdNext : '0;
      lbusColdReset <= strb.breakHit;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.respond |=> rspReady);  // R1
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.respond |=> !rspReady);  // R1
  AST_PULSE_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN)
    lbusColdReset |-> rspReady);  // R5
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !rspReady |-> (rspRdata == '0));  // R1

endmodule

// File: rtl/slave_cfg_decoder.sv
module slave_cfg_decoder
  import cfgwin_pkg::*;
#(
  parameter int WIN_AW   = 21,
  parameter int CFG_SPAN = 1024,
  parameter int SLV_BASE = 2048,
  parameter int SLV_SPAN = 1024,
  parameter int ENG_BASE = 3072,
  parameter int CFG_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [WIN_AW-1:0]           reqAddr,
  input  logic                        reqWrite,
  input  logic [31:0]                 reqWdata,
  input  logic [3:0]                  reqByteEn,
  output logic                        rspReady,
  output logic [31:0]                 rspRdata,
  output logic                        slvSel,
  output logic [$clog2(SLV_SPAN)-1:0] slvAddr,
  output logic                        slvWrite,
  output logic [31:0]                 slvWdata,
  input  logic [31:0]                 slvRdata,
  output logic                        engSel,
  output logic [WIN_AW-1:0]           engAddr,
  output logic                        engWrite,
  output logic [31:0]                 engWdata,
  input  logic [31:0]                 engRdata,
  output logic                        lbusColdReset
);

  localparam int CFG_IDX_W = $clog2(CFG_SPAN) - 2;

  strobe_t strb;
  logic [CFG_IDX_W-1:0] cfgWordIdx;

  sctd_ctrl #(
    .WIN_AW(WIN_AW), .CFG_SPAN(CFG_SPAN), .SLV_BASE(SLV_BASE),
    .SLV_SPAN(SLV_SPAN), .ENG_BASE(ENG_BASE), .BREAK_WORDS(2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .strb(strb), .cfgWordIdx(cfgWordIdx),
    .slvSel(slvSel), .slvAddr(slvAddr), .slvWrite(slvWrite), .slvWdata(slvWdata),
    .engSel(engSel), .engAddr(engAddr), .engWrite(engWrite), .engWdata(engWdata)
  );

  sctd_datapath #(
    .CFG_IDX_W(CFG_IDX_W), .CFG_WORDS(CFG_WORDS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWordIdx(cfgWordIdx),
    .slvRdata(slvRdata), .engRdata(engRdata),
    .rspReady(rspReady), .rspRdata(rspRdata), .lbusColdReset(lbusColdReset)
  );

endmodule

// File: tb/tb_slave_cfg_decoder.sv
module tb_slave_cfg_decoder;

  typedef struct packed {
    logic        wr;
    logic [20:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] expData;
    logic        expCold;
    logic [1:0]  expSel;   // bit0 slave port, bit1 engine port
    logic [20:0] expFwd;
  } vec_t;

  localparam int NVEC = 21;
  localparam logic [31:0] BRK = 32'hC0DE0000;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 21'h000000, 32'h0, 4'hF, 32'hC0022D15, 1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h000004, 32'h0, 4'hF, 32'h8001102C, 1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h000008, 32'h0, 4'hF, 32'h8001503A, 1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h00000C, 32'h0, 4'hF, 32'h80011067, 1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h000010, 32'h0, 4'hF, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h0003FC, 32'h0, 4'hF, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b1, 21'h000000, BRK,   4'hF, 32'h0,        1'b1, 2'b00, 21'h0},
    '{1'b1, 21'h000004, BRK,   4'hF, 32'h0,        1'b1, 2'b00, 21'h0},
    '{1'b1, 21'h000008, BRK,   4'hF, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b1, 21'h000000, 32'hC0DE0001, 4'hF, 32'h0, 1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h000000, 32'h0, 4'h7, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b1, 21'h000000, BRK,   4'hE, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h000002, 32'h0, 4'hF, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h000400, 32'h0, 4'hF, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b1, 21'h0007FC, BRK,   4'hF, 32'h0,        1'b0, 2'b00, 21'h0},
    '{1'b0, 21'h000804, 32'h0, 4'hF, 32'h5A5A0004, 1'b0, 2'b01, 21'h004},
    '{1'b0, 21'h000BFC, 32'h0, 4'hF, 32'h5A5A03FC, 1'b0, 2'b01, 21'h3FC},
    '{1'b0, 21'h000C10, 32'h0, 4'hF, 32'hE0000010, 1'b0, 2'b10, 21'h010},
    '{1'b1, 21'h000C00, 32'h12345678, 4'hF, 32'h0, 1'b0, 2'b10, 21'h000},
    '{1'b0, 21'h1FFFFC, 32'h0, 4'hF, 32'hE01FF3FC, 1'b0, 2'b10, 21'h1FF3FC},
    '{1'b0, 21'h000004, 32'h0, 4'hF, 32'h8001102C, 1'b0, 2'b00, 21'h0}
  };

  function automatic string vecTag(input int i);
    case (i)
      0:              return "R2";
      1, 2, 3:        return "R3";
      4, 5:           return "R4";
      6, 7:           return "R5";
      8, 9, 20:       return "R6";
      10, 11, 12:     return "R7";
      13, 14:         return "R10";
      15, 16:         return "R8";
      default:        return "R9";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [20:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [3:0] reqByteEn = '0;
  logic rspReady, slvSel, slvWrite, engSel, engWrite, lbusColdReset;
  logic [31:0] rspRdata, slvWdata, engWdata, slvRdata, engRdata;
  logic [9:0] slvAddr;
  logic [20:0] engAddr;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // Downstream models: data derived from the forwarded address
  assign slvRdata = 32'h5A5A0000 ^ {22'h0, slvAddr};
  assign engRdata = 32'hE0000000 | {11'h0, engAddr};

  slave_cfg_decoder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .rspReady(rspReady), .rspRdata(rspRdata),
    .slvSel(slvSel), .slvAddr(slvAddr), .slvWrite(slvWrite), .slvWdata(slvWdata),
    .slvRdata(slvRdata), .engSel(engSel), .engAddr(engAddr), .engWrite(engWrite),
    .engWdata(engWdata), .engRdata(engRdata), .lbusColdReset(lbusColdReset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ready", {31'h0, rspReady}, 32'h0);
    chk("R1 reset data", rspRdata, 32'h0);
    chk("R1 reset pulse", {31'h0, lbusColdReset}, 32'h0);
    chk("R1 reset sel", {30'h0, engSel, slvSel}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      reqValid  = 1'b1;
      reqAddr   = VECS[i].addr;
      reqWrite  = VECS[i].wr;
      reqWdata  = VECS[i].wdata;
      reqByteEn = VECS[i].be;
      #1;
      chk({vecTag(i), " sel"}, {30'h0, engSel, slvSel}, {30'h0, VECS[i].expSel});
      if (VECS[i].expSel[0])
        chk({vecTag(i), " slave addr"}, {22'h0, slvAddr}, {11'h0, VECS[i].expFwd});
      if (VECS[i].expSel[1]) begin
        chk({vecTag(i), " engine addr"}, {11'h0, engAddr}, {11'h0, VECS[i].expFwd});
        chk({vecTag(i), " engine write"}, {31'h0, engWrite}, {31'h0, VECS[i].wr});
        if (VECS[i].wr) chk({vecTag(i), " engine wdata"}, engWdata, VECS[i].wdata);
      end
      @(negedge clk);
      reqValid = 1'b0;
      chk({vecTag(i), " R1 ready"}, {31'h0, rspReady}, 32'h1);
      chk({vecTag(i), " data"}, rspRdata, VECS[i].expData);
      chk({vecTag(i), " pulse"}, {31'h0, lbusColdReset}, {31'h0, VECS[i].expCold});
      #1;
      chk({vecTag(i), " sel after req"}, {30'h0, engSel, slvSel}, 32'h0);
      @(negedge clk);
      chk("R1 idle ready", {31'h0, rspReady}, 32'h0);
      chk("R5 pulse width", {31'h0, lbusColdReset}, 32'h0);
    end

    // Back-to-back requests: table word then slave port (R1, R2, R8)
    reqValid = 1'b1; reqWrite = 1'b0; reqByteEn = 4'hF; reqAddr = 21'h000000;
    @(negedge clk);
    chk("R1 b2b ready 1", {31'h0, rspReady}, 32'h1);
    chk("R2 b2b data", rspRdata, 32'hC0022D15);
    reqAddr = 21'h000800;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1 b2b ready 2", {31'h0, rspReady}, 32'h1);
    chk("R8 b2b data", rspRdata, 32'h5A5A0000);
    @(negedge clk);
    chk("R1 b2b idle", {31'h0, rspReady}, 32'h0);

    // Slave port write passes data and direction (R8)
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 21'h000A00; reqWdata = 32'hCAFEF00D;
    #1;
    chk("R8 slave write sel", {31'h0, slvSel}, 32'h1);
    chk("R8 slave write dir", {31'h0, slvWrite}, 32'h1);
    chk("R8 slave wdata", slvWdata, 32'hCAFEF00D);
    chk("R8 slave write addr", {22'h0, slvAddr}, 32'h200);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 slave write rdata", rspRdata, 32'h0);
    @(negedge clk);

    done = 1'b1;
    summary();
  end

endmodule